// File: doc/BRIEF.md
# Fixed-Point to Floating-Point Converter

This block turns a signed two's-complement fixed-point number into an IEEE 754 half, single or double precision value. The caller supplies a 64-bit operand, says whether only its low 32 bits count, and gives a 6-bit scale field. The number of fraction bits is 64 minus that field. The value that gets converted is the integer divided by two raised to that fraction count. One shared datapath normalises the magnitude with a leading-zero count and rounds once at a position set by the chosen format. It handles half-precision subnormals and half-precision overflow.

The converted word is placed in the low bits of a 128-bit result. In merge mode the remaining bits come from the old destination value given with the request. Otherwise they are cleared. Encodings that are not allowed raise an illegal flag and leave the destination untouched. Inexact and overflow events either raise a trap-request pulse or set a sticky status flag, depending on a per-event trap enable. Each request is marked with a valid strobe and its answer appears exactly one clock later.

Top module: `fxToFloat`

## Requirements
- R1: With `srcWide` = 0 only `srcData[31:0]` is used, read as a signed 32-bit number, and the upper 32 bits have no effect. With `srcWide` = 1 all 64 bits are read as signed.
- R2: `fmtSel` 2'b00 selects single, 2'b01 double and 2'b11 half precision. Three cases are illegal: code 2'b10, code 2'b11 while `halfEnable` is 0, and `srcWide` = 0 with `scaleSel[5]` = 0. For an illegal request `illegal` is 1, `result` equals `oldDest`, and no flag or trap is raised.
- R3: The result is the correctly rounded value of the signed integer divided by 2^(64 − `scaleSel`). `roundMode` encodes the rounding: 2'b00 nearest with ties to even, 2'b01 toward +infinity, 2'b10 toward −infinity, 2'b11 toward zero.
- R4: A zero operand gives +0 with no flags raised. The most negative operand of either width converts with magnitude 2^(width−1).
- R5: Inexact is raised exactly when the rounded result differs from the exact value.
- R6: In half precision, a rounded magnitude above 65504 raises overflow and inexact. The result is then infinity when rounding is to nearest or is directed away from zero for that sign, and ±65504 otherwise.
- R7: Half-precision values below the normal range are rounded to a subnormal, or to a zero carrying the operand's sign.
- R8: With `mergeEn` = 1, the bits of `result` above the format width (16, 32 or 64) equal those of `oldDest`. With `mergeEn` = 0 they are zero.
- R9: When an event's trap enable is 1, `trapReq` pulses together with `outValid` and the matching flag is unchanged. When the enable is 0, the flag is set and stays set until reset.
- R10: `outValid` follows `inValid` by exactly one clock. After reset `outValid`, `illegal`, `trapReq`, both flags and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe |
| srcData | input | 64 | Fixed-point operand |
| srcWide | input | 1 | 1: 64-bit operand, 0: 32-bit operand |
| fmtSel | input | 2 | Output format code |
| scaleSel | input | 6 | Scale field; fraction bits = 64 − scaleSel |
| roundMode | input | 2 | Rounding-mode code |
| mergeEn | input | 1 | Keep upper destination bits |
| oldDest | input | 128 | Previous destination value |
| halfEnable | input | 1 | Permits half-precision output |
| trapEnInexact | input | 1 | Inexact event requests a trap |
| trapEnOverflow | input | 1 | Overflow event requests a trap |
| outValid | output | 1 | Result strobe, one clock after inValid |
| result | output | 128 | Converted and merged destination value |
| illegal | output | 1 | Request encoding was not allowed |
| flagInexact | output | 1 | Sticky inexact flag |
| flagOverflow | output | 1 | Sticky overflow flag |
| trapReq | output | 1 | Trap request pulse |

## Verification
The datapath holds no state between requests, so a wrong leading-zero count, denormal shift or rounding decision shows up in the `result` word on the very cycle `outValid` rises for that request. The same is true of a wrong trap-enable decision, which shows up in `trapReq` on that cycle. The sticky flags are the only lasting state. A flag that is set wrongly, or cleared wrongly, stays visible at the ports from the next response until reset, and the bench catches it by probing the flags after both inexact and exact requests.

// File: rtl/fx2f_pkg.sv
`timescale 1ns/1ps
package fx2f_pkg;
  typedef enum logic [1:0] {
    FMT_SINGLE = 2'b00,
    FMT_DOUBLE = 2'b01,
    FMT_RSVD   = 2'b10,
    FMT_HALF   = 2'b11
  } fmtE;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_UP      = 2'b01,
    RND_DOWN    = 2'b10,
    RND_ZERO    = 2'b11
  } roundE;

  typedef struct packed {
    logic fire;
    logic illegal;
    logic wide;
    logic merge;
    fmtE  fmt;
  } strobeT;
endpackage

// File: rtl/fx2fLzc.sv
`timescale 1ns/1ps
module fx2fLzc #(
  parameter int W = 64,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  value,
  output logic [CW-1:0] count
);
  // the highest set bit is found last, so its count wins
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (value[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fx2fControl.sv
`timescale 1ns/1ps
module fx2fControl import fx2f_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       srcWide,
  input  logic [1:0] fmtSel,
  input  logic       scaleTop,
  input  logic       mergeEn,
  input  logic       halfEnable,
  input  logic       trapEnInexact,
  input  logic       trapEnOverflow,
  input  logic       rawInexact,
  input  logic       rawOverflow,
  output strobeT     strobes,
  output logic       outValid,
  output logic       illegal,
  output logic       flagInexact,
  output logic       flagOverflow,
  output logic       trapReq
);
  logic illegalDec;
  logic excInexact;
  logic excOverflow;

  always_comb begin
    illegalDec = (fmtE'(fmtSel) == FMT_RSVD)
               || (fmtE'(fmtSel) == FMT_HALF && !halfEnable)
               || (!srcWide && !scaleTop);
    excInexact  = !illegalDec && rawInexact;
    excOverflow = !illegalDec && rawOverflow;
    strobes.fire    = inValid;
    strobes.illegal = illegalDec;
    strobes.wide    = srcWide;
    strobes.merge   = mergeEn;
    strobes.fmt     = fmtE'(fmtSel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      illegal      <= 1'b0;
      trapReq      <= 1'b0;
      flagInexact  <= 1'b0;
      flagOverflow <= 1'b0;
    end else begin
      outValid <= inValid;
      illegal  <= inValid && illegalDec;
      trapReq  <= inValid && ((excInexact && trapEnInexact)
                           || (excOverflow && trapEnOverflow));
      if (inValid) begin
        flagInexact  <= flagInexact  || (excInexact  && !trapEnInexact);
        flagOverflow <= flagOverflow || (excOverflow && !trapEnOverflow);
      end
    end
  end

  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !trapReq && !illegal));
  assert_illegal_no_trap_R2: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !trapReq);
  assert_sticky_inexact_R9: assert property (@(posedge clk) disable iff (!rstN)
    flagInexact |=> flagInexact);
  assert_sticky_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    flagOverflow |=> flagOverflow);
endmodule

// File: rtl/fx2fDatapath.sv
`timescale 1ns/1ps
module fx2fDatapath import fx2f_pkg::*; #(
  parameter int SRC_W   = 64,
  parameter int DEST_W  = 128,
  parameter int SCALE_W = 6,
  localparam int HALF_W = SRC_W / 2,
  localparam int EXT_W  = 2 * SRC_W,
  localparam int CNT_W  = $clog2(SRC_W) + 1,
  localparam int FULL_SCALE = 1 << SCALE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobes,
  input  logic [SRC_W-1:0]   srcData,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic [1:0]         roundMode,
  input  logic [DEST_W-1:0]  oldDest,
  output logic [DEST_W-1:0]  result,
  output logic               rawInexact,
  output logic               rawOverflow
);
  logic [SRC_W-1:0]  srcExt;
  logic              signBit;
  logic [SRC_W-1:0]  mag;
  logic [CNT_W-1:0]  lzCount;
  logic [SRC_W-1:0]  norm;
  logic [EXT_W-1:0]  ext;
  logic [SRC_W-1:0]  kept;
  logic [SRC_W-1:0]  fracField;
  logic [SRC_W-1:0]  packWord;
  logic [SRC_W-1:0]  infPat;
  logic [SRC_W-1:0]  word;
  logic [DEST_W-1:0] fmtMask;
  logic [DEST_W-1:0] merged;
  logic guardBit, stickyBit, lsbBit, roundUp, toInf, magZero;
  int manBits, expBits, bias, fracBits, expUnb, eMin, denorm, biasedExp;

  fx2fLzc #(.W(SRC_W)) lzcInst (.value(mag), .count(lzCount));

  always_comb begin
    srcExt  = strobes.wide ? srcData
                           : {{HALF_W{srcData[HALF_W-1]}}, srcData[HALF_W-1:0]};
    signBit = srcExt[SRC_W-1];
    mag     = signBit ? (~srcExt + SRC_W'(1)) : srcExt;
    magZero = (mag == '0);
    norm    = mag << lzCount;

    case (strobes.fmt)
      FMT_HALF:   begin manBits = 10; expBits = 5;  end
      FMT_DOUBLE: begin manBits = 52; expBits = 11; end
      default:    begin manBits = 23; expBits = 8;  end
    endcase
    bias     = (1 << (expBits - 1)) - 1;
    eMin     = 1 - bias;
    fracBits = FULL_SCALE - int'(scaleSel);
    expUnb   = (SRC_W - 1) - int'(lzCount) - fracBits;
    denorm   = (expUnb < eMin) ? (eMin - expUnb) : 0;
    if (denorm > SRC_W) denorm = SRC_W;

    // leading one sits at the top of ext, shifted down for subnormals
    ext       = {norm, {SRC_W{1'b0}}} >> denorm;
    kept      = SRC_W'(ext >> (EXT_W - 1 - manBits));
    fracField = kept & ((SRC_W'(1) << manBits) - SRC_W'(1));
    lsbBit    = kept[0];
    guardBit  = ext[EXT_W - 2 - manBits];
    stickyBit = |(ext & ((EXT_W'(1) << (EXT_W - 2 - manBits)) - EXT_W'(1)));

    case (roundE'(roundMode))
      RND_NEAREST: begin roundUp = guardBit && (stickyBit || lsbBit); toInf = 1'b1; end
      RND_UP:      begin roundUp = !signBit && (guardBit || stickyBit); toInf = !signBit; end
      RND_DOWN:    begin roundUp = signBit && (guardBit || stickyBit); toInf = signBit; end
      default:     begin roundUp = 1'b0; toInf = 1'b0; end
    endcase

    biasedExp = (denorm != 0) ? 0 : expUnb + bias;
    // a carry out of the fraction moves into the exponent field by itself
    packWord  = ((SRC_W'(biasedExp) << manBits) | fracField) + SRC_W'(roundUp);
    infPat    = ((SRC_W'(1) << expBits) - SRC_W'(1)) << manBits;

    rawOverflow = !magZero && (packWord >= infPat);
    rawInexact  = !magZero && (guardBit || stickyBit || rawOverflow);
    if (magZero) word = '0;
    else begin
      word = rawOverflow ? (toInf ? infPat : infPat - SRC_W'(1)) : packWord;
      word = word | (SRC_W'(signBit) << (expBits + manBits));
    end

    fmtMask = (DEST_W'(1) << (expBits + manBits + 1)) - DEST_W'(1);
    merged  = strobes.merge ? ((oldDest & ~fmtMask) | DEST_W'(word)) : DEST_W'(word);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) result <= '0;
    else if (strobes.fire) result <= strobes.illegal ? oldDest : merged;
  end

  assert_overflow_half_R6: assert property (@(posedge clk) disable iff (!rstN)
    rawOverflow |-> (strobes.fmt == FMT_HALF));
  assert_zero_exact_R4: assert property (@(posedge clk) disable iff (!rstN)
    (srcExt == '0) |-> (!rawInexact && !rawOverflow));
  assert_lzc_top_R3: assert property (@(posedge clk) disable iff (!rstN)
    !magZero |-> norm[SRC_W-1]);
endmodule

// File: rtl/fxToFloat.sv
`timescale 1ns/1ps
module fxToFloat import fx2f_pkg::*; #(
  parameter int SRC_W   = 64,
  parameter int DEST_W  = 128,
  parameter int SCALE_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [SRC_W-1:0]   srcData,
  input  logic               srcWide,
  input  logic [1:0]         fmtSel,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic [1:0]         roundMode,
  input  logic               mergeEn,
  input  logic [DEST_W-1:0]  oldDest,
  input  logic               halfEnable,
  input  logic               trapEnInexact,
  input  logic               trapEnOverflow,
  output logic               outValid,
  output logic [DEST_W-1:0]  result,
  output logic               illegal,
  output logic               flagInexact,
  output logic               flagOverflow,
  output logic               trapReq
);
  strobeT strobes;
  logic   rawInexact;
  logic   rawOverflow;

  fx2fControl ctrlInst (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcWide(srcWide),
    .fmtSel(fmtSel), .scaleTop(scaleSel[SCALE_W-1]), .mergeEn(mergeEn),
    .halfEnable(halfEnable), .trapEnInexact(trapEnInexact),
    .trapEnOverflow(trapEnOverflow), .rawInexact(rawInexact),
    .rawOverflow(rawOverflow), .strobes(strobes), .outValid(outValid),
    .illegal(illegal), .flagInexact(flagInexact),
    .flagOverflow(flagOverflow), .trapReq(trapReq)
  );

  fx2fDatapath #(.SRC_W(SRC_W), .DEST_W(DEST_W), .SCALE_W(SCALE_W)) dpInst (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcData(srcData),
    .scaleSel(scaleSel), .roundMode(roundMode), .oldDest(oldDest),
    .result(result), .rawInexact(rawInexact), .rawOverflow(rawOverflow)
  );
endmodule

// File: tb/fxToFloat_test.sv
`timescale 1ns/1ps
module fxToFloat_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [63:0] srcData = '0;
  logic srcWide = 1'b1;
  logic [1:0] fmtSel = 2'b00;
  logic [5:0] scaleSel = 6'd32;
  logic [1:0] roundMode = 2'b00;
  logic mergeEn = 1'b0;
  logic [127:0] oldDest = '0;
  logic halfEnable = 1'b1;
  logic trapEnInexact = 1'b0;
  logic trapEnOverflow = 1'b0;
  logic outValid, illegal, flagInexact, flagOverflow, trapReq;
  logic [127:0] result;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fxToFloat uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcData(srcData),
    .srcWide(srcWide), .fmtSel(fmtSel), .scaleSel(scaleSel),
    .roundMode(roundMode), .mergeEn(mergeEn), .oldDest(oldDest),
    .halfEnable(halfEnable), .trapEnInexact(trapEnInexact),
    .trapEnOverflow(trapEnOverflow), .outValid(outValid), .result(result),
    .illegal(illegal), .flagInexact(flagInexact),
    .flagOverflow(flagOverflow), .trapReq(trapReq)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // arithmetic reference: exact quotient and remainder, no normaliser
  function automatic void refConv(input logic [63:0] src, input logic wide,
      input logic [1:0] fmt, input logic [5:0] scale, input logic [1:0] mode,
      output logic [63:0] word, output logic inx, output logic ovf);
    logic [63:0] v, mag;
    logic sgn, up, toInf;
    logic [127:0] q, remv, halfv;
    int fb, p, m, w, b, e, eff, s, biased;
    v = wide ? src : {{32{src[31]}}, src[31:0]};
    sgn = v[63];
    mag = sgn ? 64'(0) - v : v;
    word = '0; inx = 1'b0; ovf = 1'b0;
    if (mag == 0) return;
    fb = 64 - int'(scale);
    p = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) p = i;
    case (fmt)
      2'b11:   begin m = 10; w = 5;  end
      2'b01:   begin m = 52; w = 11; end
      default: begin m = 23; w = 8;  end
    endcase
    b = (1 << (w - 1)) - 1;
    e = p - fb;
    eff = (e < 1 - b) ? 1 - b : e;
    s = eff - m + fb;
    remv = '0; halfv = '0;
    if (s <= 0) q = {64'b0, mag} << (-s);
    else begin
      q = {64'b0, mag} >> s;
      remv = {64'b0, mag} - (q << s);
      halfv = 128'(1) << (s - 1);
    end
    inx = (remv != 0);
    case (mode)
      2'b00: begin up = (remv > halfv) || (inx && remv == halfv && q[0]); toInf = 1'b1; end
      2'b01: begin up = inx && !sgn; toInf = !sgn; end
      2'b10: begin up = inx && sgn; toInf = sgn; end
      default: begin up = 1'b0; toInf = 1'b0; end
    endcase
    q = q + 128'(up);
    if (q >= (128'(1) << (m + 1))) begin q = q >> 1; eff++; end
    biased = (q >= (128'(1) << m)) ? eff + b : 0;
    if (biased >= (1 << w) - 1) begin
      ovf = 1'b1; inx = 1'b1;
      word = ((64'(1) << w) - 64'(1)) << m;
      if (!toInf) word = word - 64'(1);
    end else
      word = (64'(biased) << m) | (q[63:0] & ((64'(1) << m) - 64'(1)));
    word = word | (64'(sgn) << (w + m));
  endfunction

  task automatic drive(input logic [63:0] src, input logic wide, input logic [1:0] fmt,
      input logic [5:0] scale, input logic [1:0] mode, input logic merge,
      input logic [127:0] old, input logic enI, input logic enO);
    @(negedge clk);
    inValid = 1'b1; srcData = src; srcWide = wide; fmtSel = fmt; scaleSel = scale;
    roundMode = mode; mergeEn = merge; oldDest = old;
    trapEnInexact = enI; trapEnOverflow = enO;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic runVec(input logic [63:0] src, input logic wide, input logic [1:0] fmt,
      input logic [5:0] scale, input logic [1:0] mode, input logic merge,
      input logic [127:0] old);
    logic [63:0] word;
    logic inx, ovf;
    logic [127:0] mask, expFull;
    string tag;
    refConv(src, wide, fmt, scale, mode, word, inx, ovf);
    mask = (fmt == 2'b11) ? 128'hFFFF : (fmt == 2'b00) ? 128'hFFFF_FFFF
                                                      : 128'hFFFF_FFFF_FFFF_FFFF;
    expFull = merge ? ((old & ~mask) | 128'(word)) : 128'(word);
    if (src == 64'h8000_0000_0000_0000 || (wide ? src : {32'b0, src[31:0]}) == 0) tag = "R4";
    else if (fmt == 2'b11 && ovf) tag = "R6";
    else if (fmt == 2'b11 && word[14:10] == 5'd0) tag = "R7";
    else if (!wide) tag = "R1";
    else tag = "R3";
    drive(src, wide, fmt, scale, mode, merge, old, 1'b1, 1'b0);
    check("R10 outValid", 128'(outValid), 128'(1));
    check({tag, " word"}, result & mask, expFull & mask);
    check("R8 upper", result & ~mask, expFull & ~mask);
    check("R5 inexact trap", 128'(trapReq), 128'(inx));
    drive(src, wide, fmt, scale, mode, merge, old, 1'b0, 1'b1);
    check("R6 overflow trap", 128'(trapReq), 128'(ovf));
    check("R2 legal", 128'(illegal), 128'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R10 watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [0:19];
    int wideScales [0:10];
    int narrowScales [0:5];
    wideScales = '{0, 1, 2, 31, 32, 33, 48, 53, 54, 60, 63};
    narrowScales = '{32, 33, 40, 48, 54, 63};
    pats[0] = 64'h0; pats[1] = 64'h1; pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[3] = 64'h8000_0000_0000_0000; pats[4] = 64'h7FFF_FFFF_FFFF_FFFF;
    pats[5] = 64'h3; pats[6] = 64'h00FF_F800_0000_0000;
    pats[7] = 64'h0010_0000_0000_0001; pats[8] = 64'hFFFF_FFFF_FFFF_F001;
    pats[9] = 64'h0000_0000_FFFF_FFFF; pats[10] = 64'h1234_5678_9ABC_DEF0;
    pats[11] = 64'h0000_0000_8000_0000; pats[12] = 64'h1FFE0;
    pats[13] = 64'h1FFF0; pats[14] = 64'hFFFF_FFFF_FFFE_0010;
    for (int i = 15; i < 20; i++) pats[i] = {$urandom, $urandom};

    repeat (3) @(negedge clk);
    check("R10 reset outValid", 128'(outValid), 128'(0));
    check("R10 reset flags", 128'({flagInexact, flagOverflow, trapReq, illegal}), 128'(0));
    check("R10 reset result", result, 128'(0));
    rstN = 1'b1;

    // R9: sticky flags with traps disabled
    drive(64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 2'b01, 6'd63, 2'b11, 1'b0, '0, 1'b0, 1'b0);
    check("R9 inexact flag set", 128'(flagInexact), 128'(1));
    check("R9 no trap", 128'(trapReq), 128'(0));
    check("R9 overflow flag clear", 128'(flagOverflow), 128'(0));
    drive(64'h1, 1'b1, 2'b00, 6'd63, 2'b00, 1'b0, '0, 1'b0, 1'b0);
    check("R9 inexact flag held", 128'(flagInexact), 128'(1));
    drive(64'h1FFE0, 1'b1, 2'b11, 6'd63, 2'b00, 1'b0, '0, 1'b0, 1'b0);
    check("R9 overflow flag set", 128'(flagOverflow), 128'(1));
    check("R6 inf on nearest", result, 128'h7C00);
    drive(64'h1, 1'b1, 2'b00, 6'd63, 2'b00, 1'b0, '0, 1'b1, 1'b1);
    check("R9 overflow flag held", 128'(flagOverflow), 128'(1));

    // R2: illegal encodings keep the destination and stay quiet
    drive(64'h3, 1'b1, 2'b10, 6'd63, 2'b00, 1'b1, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_1122_3344, 1'b1, 1'b1);
    check("R2 reserved illegal", 128'(illegal), 128'(1));
    check("R2 reserved keeps dest", result, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_1122_3344);
    check("R2 reserved no trap", 128'(trapReq), 128'(0));
    halfEnable = 1'b0;
    drive(64'h3, 1'b1, 2'b11, 6'd63, 2'b00, 1'b0, 128'h5555, 1'b1, 1'b1);
    check("R2 half disabled illegal", 128'(illegal), 128'(1));
    check("R2 half disabled keeps dest", result, 128'h5555);
    halfEnable = 1'b1;
    drive(64'h3, 1'b0, 2'b00, 6'd31, 2'b00, 1'b0, 128'h7777, 1'b1, 1'b1);
    check("R2 narrow scale illegal", 128'(illegal), 128'(1));
    check("R2 narrow scale keeps dest", result, 128'h7777);
    @(negedge clk);
    check("R10 idle outValid", 128'(outValid), 128'(0));

    // sweep over formats, modes, scales and operands
    for (int f = 0; f < 4; f++) begin
      if (f == 2) continue;
      for (int md = 0; md < 4; md++) begin
        for (int si = 0; si < 11; si++)
          for (int pi = 0; pi < 20; pi++)
            runVec(pats[pi], 1'b1, 2'(f), 6'(wideScales[si]), 2'(md), pi[0],
                   {$urandom, $urandom, $urandom, $urandom});
        for (int si = 0; si < 6; si++)
          for (int pi = 0; pi < 20; pi++)
            runVec({$urandom, pats[pi][31:0]}, 1'b0, 2'(f), 6'(narrowScales[si]), 2'(md),
                   pi[0], {$urandom, $urandom, $urandom, $urandom});
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule